// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Router

This block gathers level-sensitive interrupt lines and sends each one to a set of CPUs chosen by software. It sits between the peripherals and up to four processor cores. Sources 0 and 1 are not peripherals. They are summary lines from a doorbell unit: source 0 summarises inter-processor messages and source 1 summarises message-signalled interrupts. The router handles them exactly like any other line. Because they carry the lowest IDs, they win whenever they qualify.

Software reaches the block through two plain register ports.

- **Shared port.** It holds a per-source enable and a per-source routing word. The enables are not read-modify-write registers: a source index is written to a "set" address or to a "clear" address.
- **Per-CPU port.** A `c_sel` input names the issuing CPU. Through this port that CPU masks or unmasks sources for itself, again by writing an index. It also reads its acknowledge word, which holds the lowest qualifying source ID. When nothing qualifies, the word holds the idle code 1023.

Lines are level-sensitive, and an acknowledge read has no side effect. The hardware does nothing to stop two CPUs from taking the same source. Software is expected to route each source to a single CPU.

Reads have a latency of one cycle on both ports. When a read strobe is low, the read data returns zero. The CPU request lines are registered: each one follows the qualifying condition one cycle later.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the following hold.
  - Every global enable is clear.
  - Every per-CPU mask bit is set.
  - Every routing word reads zero.
  - All `cpu_irq_o` bits are low.
  - An acknowledge read on any CPU returns 1023.
- R2: Writing a value v < NSRC to shared address 0x30 sets the enable of source v, and writing it to 0x34 clears that enable. A written value of NSRC or more changes nothing. No truncation of the value takes place.
- R3: Writing v to per-CPU address 0x48 masks source v for the CPU named by `c_sel`. Writing v to 0x4C unmasks it. The masks of the other CPUs are unchanged.
- R4: Source s has a routing word at shared address 0x100 + 4*s.
  - Bit c of this word routes the source to CPU c.
  - Only the low NCPU bits are stored.
  - A read returns the stored bits, with every higher bit zero.
- R5: `cpu_irq_o[c]` is high one cycle after all of the following are true: some source line is high, it is enabled, it is routed to c, and it is unmasked for c. It drops one cycle after that stops being true, for example when the line falls.
- R6: Source TIMER_ID (default 5) ignores the global enable. It is gated only by its routing and by the per-CPU mask.
- R7: A read of per-CPU address 0x44 returns, in bits [9:0] one cycle later, the lowest qualifying source ID for CPU `c_sel`. If no source qualifies, it returns 1023. The read has no side effect.
- R8: A read of shared address 0x00 returns NSRC in bits [11:2], and zero in all other bits.
- R9: A source routed to several CPUs raises every one of them, and each of those CPUs acknowledges the same ID.
- R10: Source IDs 0 and 1, the doorbell summary lines, qualify through enable, routing and mask like any other source. They take precedence over peripheral IDs 2 and higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NSRC | Level source lines; bits 0 and 1 are doorbell summaries |
| g_we | input | 1 | Shared-port write strobe |
| g_re | input | 1 | Shared-port read strobe |
| g_addr | input | G_AW | Shared-port byte address |
| g_wdata | input | DW | Shared-port write data |
| g_rdata | output | DW | Shared-port read data, one cycle after `g_re` |
| c_sel | input | CW | Index of the CPU issuing the per-CPU access |
| c_we | input | 1 | Per-CPU write strobe |
| c_re | input | 1 | Per-CPU read strobe |
| c_addr | input | C_AW | Per-CPU byte address |
| c_wdata | input | DW | Per-CPU write data |
| c_rdata | output | DW | Per-CPU read data, one cycle after `c_re` |
| cpu_irq_o | output | NCPU | Registered interrupt request, one bit per CPU |

## Verification
The routing function is tried against a fixed configuration.

- **Configuration.** Each source goes to CPU s mod 4. Source 7 is disabled, source 5 (the timer) is never enabled, and CPU 2 masks source 10.
- **Input patterns.** The source vectors were chosen to separate distinct effects:
  - single lines, which test routing alone;
  - the disabled and masked lines, which test gating;
  - the bare timer line, which tests the enable bypass;
  - all lines high, which gives each CPU a different winner;
  - two lines that share one CPU, which tests lowest-ID selection;
  - doorbell lines together with peripherals, which tests the precedence of IDs 0 and 1.
- **Directed cases.** Separate tests cover the following:
  - the reset mask state;
  - an out-of-range index that would alias source 2 if the index were truncated;
  - a mask written for one CPU leaving the other CPUs unchanged;
  - a routing word with two CPUs set;
  - routing-word readback with the high bits discarded.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Width of a source ID in the acknowledge word
  localparam int ID_W = 10;
  // Returned when no source qualifies
  localparam int IDLE_ID = 1023;

  // Shared-bank byte offsets
  localparam int G_CTRL       = 'h000;
  localparam int G_EN_SET     = 'h030;
  localparam int G_EN_CLR     = 'h034;
  localparam int G_ROUTE_BASE = 'h100;

  // Per-CPU-bank byte offsets
  localparam int C_ACK     = 'h44;
  localparam int C_MSK_SET = 'h48;
  localparam int C_MSK_CLR = 'h4C;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NCPU = 4,
  parameter int AW   = 12,
  parameter int DW   = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic                       re,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [DW-1:0]              rdata,
  output logic [NSRC-1:0]            en_o,
  output logic [NSRC-1:0][NCPU-1:0]  route_o
);
  localparam int SW      = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int RT_LAST = G_ROUTE_BASE + 4 * NSRC - 4;

  logic                      idx_ok;
  logic [SW-1:0]             idx;
  logic                      rt_hit;
  logic [SW-1:0]             rt_idx;
  logic [NSRC-1:0]           en_q;
  logic [NSRC-1:0][NCPU-1:0] route_q;
  logic [DW-1:0]             rd_next;

  // Whole written value is compared, so large values never alias a source
  assign idx_ok = (wdata < DW'(NSRC));
  assign idx    = wdata[SW-1:0];

  assign rt_hit = (int'(addr) >= G_ROUTE_BASE) && (int'(addr) <= RT_LAST) &&
                  (addr[1:0] == 2'b00);
  assign rt_idx = SW'((addr - AW'(G_ROUTE_BASE)) >> 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (we && idx_ok) begin
      if (addr == AW'(G_EN_SET))      en_q[idx] <= 1'b1;
      else if (addr == AW'(G_EN_CLR)) en_q[idx] <= 1'b0;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_route
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  route_q[s] <= '0;
      else if (we && rt_hit && rt_idx == SW'(s))   route_q[s] <= wdata[NCPU-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (addr == AW'(G_CTRL))  rd_next[ID_W+1:2]  = ID_W'(NSRC);
    else if (rt_hit)          rd_next[NCPU-1:0] = route_q[rt_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= re ? rd_next : '0;
  end

  assign en_o    = en_q;
  assign route_o = route_q;

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx_ok && addr == AW'(G_EN_SET)) |=> en_q[$past(idx)]);
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx_ok && addr == AW'(G_EN_CLR)) |=> !en_q[$past(idx)]);
  // R2
  en_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !idx_ok) |=> $stable(en_q));
  // R4
  route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && rt_hit) |=> route_q[$past(rt_idx)] == $past(wdata[NCPU-1:0]));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int NCPU = 4,
  parameter int AW   = 8,
  parameter int DW   = 32,
  parameter int CW   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [CW-1:0]              sel,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wdata,
  output logic [NCPU-1:0][NSRC-1:0]  mask_o
);
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic                      idx_ok;
  logic [SW-1:0]             idx;
  logic [NCPU-1:0][NSRC-1:0] mask_q;

  assign idx_ok = (wdata < DW'(NSRC));
  assign idx    = wdata[SW-1:0];

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[c] <= '1;
      end else if (we && idx_ok && sel == CW'(c)) begin
        if (addr == AW'(C_MSK_SET))      mask_q[c][idx] <= 1'b1;
        else if (addr == AW'(C_MSK_CLR)) mask_q[c][idx] <= 1'b0;
      end
    end

    // R3
    mask_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!we || sel != CW'(c)) |=> $stable(mask_q[c]));
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_route_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  cand,
  output logic             any,
  output logic [ID_W-1:0]  id
);
  logic [NSRC-1:0] below;

  // Downward scan: the last hit written is the lowest index
  always_comb begin
    any = 1'b0;
    id  = ID_W'(IDLE_ID);
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any = 1'b1;
        id  = ID_W'(i);
      end
    end
  end

  assign below = (NSRC'(1) << id) - NSRC'(1);

  // R7
  pick_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> cand[id]);
  // R7
  pick_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((cand & below) == '0));
  // R7
  pick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> (id == ID_W'(IDLE_ID)));
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NSRC     = 32,
  parameter int NCPU     = 4,
  parameter int TIMER_ID = 5,
  parameter int G_AW     = 12,
  parameter int C_AW     = 8,
  parameter int DW       = 32,
  localparam int CW      = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_src_i,
  input  logic             g_we,
  input  logic             g_re,
  input  logic [G_AW-1:0]  g_addr,
  input  logic [DW-1:0]    g_wdata,
  output logic [DW-1:0]    g_rdata,
  input  logic [CW-1:0]    c_sel,
  input  logic             c_we,
  input  logic             c_re,
  input  logic [C_AW-1:0]  c_addr,
  input  logic [DW-1:0]    c_wdata,
  output logic [DW-1:0]    c_rdata,
  output logic [NCPU-1:0]  cpu_irq_o
);
  localparam logic [NSRC-1:0] TMR_BIT = NSRC'(1) << TIMER_ID;

  logic [NSRC-1:0]            en;
  logic [NSRC-1:0][NCPU-1:0]  route;
  logic [NCPU-1:0][NSRC-1:0]  mask;
  logic [NSRC-1:0]            gate;
  logic [NCPU-1:0][NSRC-1:0]  cand;
  logic [NCPU-1:0]            any;
  logic [NCPU-1:0][ID_W-1:0]  pick_id;
  logic [NCPU-1:0]            irq_q;

  irq_src_bank #(.NSRC(NSRC), .NCPU(NCPU), .AW(G_AW), .DW(DW)) u_src (
    .clk(clk), .rst_n(rst_n), .we(g_we), .re(g_re), .addr(g_addr),
    .wdata(g_wdata), .rdata(g_rdata), .en_o(en), .route_o(route)
  );

  irq_mask_bank #(.NSRC(NSRC), .NCPU(NCPU), .AW(C_AW), .DW(DW), .CW(CW)) u_mask (
    .clk(clk), .rst_n(rst_n), .we(c_we), .sel(c_sel), .addr(c_addr),
    .wdata(c_wdata), .mask_o(mask)
  );

  // Timer source bypasses the shared enable
  assign gate = en | TMR_BIT;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign cand[c][s] = irq_src_i[s] & gate[s] & route[s][c] & ~mask[c][s];
    end

    irq_pick #(.NSRC(NSRC)) u_pick (
      .clk(clk), .rst_n(rst_n), .cand(cand[c]), .any(any[c]), .id(pick_id[c])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[c] <= 1'b0;
      else        irq_q[c] <= any[c];
    end

    // R5
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any[c] |=> !cpu_irq_o[c]);
    // R6
    timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_src_i[TIMER_ID] && route[TIMER_ID][c] && !mask[c][TIMER_ID]) |=> cpu_irq_o[c]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                c_rdata <= '0;
    else if (c_re && c_addr == C_AW'(C_ACK))   c_rdata <= DW'(pick_id[c_sel]);
    else                                       c_rdata <= '0;
  end

  assign cpu_irq_o = irq_q;

  // R7
  ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_re && c_addr == C_AW'(C_ACK) && !any[c_sel]) |=> (c_rdata[ID_W-1:0] == ID_W'(IDLE_ID)));
endmodule

// File: tb/irq_route_ctrl_bench.sv
module irq_route_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src_i = '0;
  logic        g_we = 1'b0, g_re = 1'b0;
  logic [11:0] g_addr = '0;
  logic [31:0] g_wdata = '0;
  logic [31:0] g_rdata;
  logic [1:0]  c_sel = '0;
  logic        c_we = 1'b0, c_re = 1'b0;
  logic [7:0]  c_addr = '0;
  logic [31:0] c_wdata = '0;
  logic [31:0] c_rdata;
  logic [3:0]  cpu_irq_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_route_ctrl u_irq_route_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src_i),
    .g_we(g_we), .g_re(g_re), .g_addr(g_addr), .g_wdata(g_wdata), .g_rdata(g_rdata),
    .c_sel(c_sel), .c_we(c_we), .c_re(c_re), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_rdata(c_rdata), .cpu_irq_o(cpu_irq_o)
  );

  // Config: source s routed to CPU s%4, all enabled except 5 and 7, CPU2 masks 10
  // Fields: src[75:44] irq[43:40] ack0[39:30] ack1[29:20] ack2[19:10] ack3[9:0]
  localparam logic [75:0] VEC [10] = '{
    {32'h0000_0000, 4'b0000, 10'd1023, 10'd1023, 10'd1023, 10'd1023},
    {32'h0000_0004, 4'b0100, 10'd1023, 10'd1023, 10'd2,    10'd1023},
    {32'h0000_0080, 4'b0000, 10'd1023, 10'd1023, 10'd1023, 10'd1023},
    {32'h0000_0020, 4'b0010, 10'd1023, 10'd5,    10'd1023, 10'd1023},
    {32'h0000_4400, 4'b0100, 10'd1023, 10'd1023, 10'd14,   10'd1023},
    {32'h0000_0111, 4'b0001, 10'd0,    10'd1023, 10'd1023, 10'd1023},
    {32'hFFFF_FFFF, 4'b1111, 10'd0,    10'd1,    10'd2,    10'd3},
    {32'h8800_2000, 4'b1010, 10'd1023, 10'd13,   10'd1023, 10'd27},
    {32'h0020_0200, 4'b0010, 10'd1023, 10'd9,    10'd1023, 10'd1023},
    {32'h0000_0480, 4'b0000, 10'd1023, 10'd1023, 10'd1023, 10'd1023}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic gwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); g_we = 1'b1; g_addr = a; g_wdata = d;
    @(negedge clk); g_we = 1'b0;
  endtask

  task automatic grd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); g_re = 1'b1; g_addr = a;
    @(negedge clk); g_re = 1'b0; d = g_rdata;
  endtask

  task automatic cwr(input logic [1:0] s, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); c_we = 1'b1; c_sel = s; c_addr = a; c_wdata = d;
    @(negedge clk); c_we = 1'b0;
  endtask

  task automatic crd(input logic [1:0] s, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); c_re = 1'b1; c_sel = s; c_addr = a;
    @(negedge clk); c_re = 1'b0; d = c_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {28'd0, cpu_irq_o}, 32'h0);
    for (int c = 0; c < 4; c++) begin
      crd(2'(c), 8'h44, rd);
      chk("R1 ack idle after reset", rd, 32'd1023);
    end
    grd(12'h124, rd);
    chk("R1 route word after reset", rd, 32'h0);
    // R8
    grd(12'h000, rd);
    chk("R8 source count", rd, 32'd32 << 2);

    // R1 masks set at reset: enabled and routed source still blocked
    gwr(12'h030, 32'd2);
    gwr(12'h108, 32'h1);
    irq_src_i = 32'h4;
    settle();
    chk("R1 reset mask blocks", {28'd0, cpu_irq_o}, 32'h0);
    cwr(2'd0, 8'h4C, 32'd2);
    settle();
    chk("R5 irq after unmask", {28'd0, cpu_irq_o}, 32'h1);
    crd(2'd0, 8'h44, rd);
    chk("R7 ack cpu0", rd, 32'd2);
    crd(2'd0, 8'h44, rd);
    chk("R7 ack read has no side effect", rd, 32'd2);
    crd(2'd1, 8'h44, rd);
    chk("R3 other cpu still idle", rd, 32'd1023);
    // R3 mask again for cpu0
    cwr(2'd0, 8'h48, 32'd2);
    settle();
    chk("R3 mask for cpu0", {28'd0, cpu_irq_o}, 32'h0);
    cwr(2'd0, 8'h4C, 32'd2);
    // R2 clear enable
    gwr(12'h034, 32'd2);
    settle();
    chk("R2 clear enable", {28'd0, cpu_irq_o}, 32'h0);
    // R2 out-of-range index 34 aliases 2 if truncated
    gwr(12'h030, 32'd34);
    settle();
    chk("R2 out of range set ignored", {28'd0, cpu_irq_o}, 32'h0);
    gwr(12'h030, 32'd2);
    settle();
    chk("R2 set enable", {28'd0, cpu_irq_o}, 32'h1);
    irq_src_i = '0;
    settle();
    chk("R5 drop on level fall", {28'd0, cpu_irq_o}, 32'h0);

    // Table configuration
    for (int s = 0; s < 32; s++) begin
      if (s != 5 && s != 7) gwr(12'h030, 32'(s));
      gwr(12'(12'h100 + 4 * s), 32'h1 << (s % 4));
    end
    for (int c = 0; c < 4; c++)
      for (int s = 0; s < 32; s++) cwr(2'(c), 8'h4C, 32'(s));
    cwr(2'd2, 8'h48, 32'd10);

    // Table walk: R5 irq, R7 ack, R6 timer entry, R10 doorbell entries
    for (int v = 0; v < 10; v++) begin
      irq_src_i = VEC[v][75:44];
      settle();
      chk("R5 table irq", {28'd0, cpu_irq_o}, {28'd0, VEC[v][43:40]});
      for (int c = 0; c < 4; c++) begin
        crd(2'(c), 8'h44, rd);
        chk("R7 R10 table ack", rd, {22'd0, VEC[v][39 - 10 * c -: 10]});
      end
    end

    // R9 source 9 routed to cpu1 and cpu2
    gwr(12'h124, 32'h6);
    irq_src_i = 32'h200;
    settle();
    chk("R9 two cpus raised", {28'd0, cpu_irq_o}, 32'h6);
    crd(2'd1, 8'h44, rd);
    chk("R9 cpu1 ack", rd, 32'd9);
    crd(2'd2, 8'h44, rd);
    chk("R9 cpu2 ack", rd, 32'd9);
    // R4 readback and upper bits dropped
    grd(12'h124, rd);
    chk("R4 route readback", rd, 32'h6);
    gwr(12'h124, 32'hFFFF_FFF8);
    grd(12'h124, rd);
    chk("R4 route upper bits dropped", rd, 32'h8);
    settle();
    chk("R4 reroute to cpu3", {28'd0, cpu_irq_o}, 32'h8);
    // R6 timer still obeys per-cpu mask
    cwr(2'd1, 8'h48, 32'd5);
    irq_src_i = 32'h20;
    settle();
    chk("R6 timer masked", {28'd0, cpu_irq_o}, 32'h0);
    irq_src_i = '0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule